// File: doc/BRIEF.md
# Lockstep Mode Control Register

This block is a single 32-bit control register, plus a small amount of sequencing logic, that decides whether a two-core processor cluster runs its cores in lockstep or as two independent cores. Software reaches it through a plain register bus with an address, a write enable, write data and combinational read data. A power-on reset returns every field to its default.

A mode request is stored in a three-bit field. A switch-wait field decides when the request takes effect. Either it waits for the next cluster reset, or it is applied at once. A write-pulse field starts a reset sequencer. The sequencer holds the cluster reset high for a fixed number of cycles and latches the requested mode in its first hold cycle. Only the first real change of the effective mode after power-on is honoured. A sticky flag records that change and freezes the mode from then on.

A separate three-bit field enables one ROM wait cycle. This is needed when the core clock runs at twice the interconnect clock. Every control field is three bits wide, so one flipped bit cannot select an unusual setting by itself.

Top module: `lockstep_ctrl`

## Requirements
- R1: After power-on reset the register reads 0x00000707: the mode request (bits 2:0) is 3'b111, the switch-wait control (bits 10:8) is 3'b111 and the ROM wait control (bits 26:24) is 3'b000. lockstep_mode is 1, rom_wait_en is 0, cluster_rst is 0 and mode_locked is 0.
- R2: Bits 31:27, 23:19, 15:11 and 7:3 always read as zero, and writes to them are ignored. Reads at any other address return zero, and writes to any other address have no effect.
- R3: Only a mode request of 3'b000 asks for dual-core mode (lockstep_mode 0). Every other value asks for lockstep (lockstep_mode 1).
- R4: While the switch-wait control is 3'b111, a new mode request does not change lockstep_mode until the reset sequencer runs.
- R5: While the switch-wait control holds any value other than 3'b111, a differing mode request is applied on the second clock edge after the write that stores it.
- R6: Writing 3'b111 to bits 18:16 starts the reset sequencer. Any other value written there has no effect, and the field always reads as zero.
- R7: Once started, cluster_rst is high for exactly RST_CYCLES consecutive cycles, beginning after the clock edge that takes the trigger write. A pending mode request is latched on the next edge.
- R8: A trigger written while the sequencer is already running is ignored and does not lengthen the reset.
- R9: The first change of lockstep_mode sets mode_locked. mode_locked stays set until power-on reset, and while it is set lockstep_mode does not change.
- R10: rom_wait_en becomes 1 after the edge of a write that stores 3'b111 in bits 26:24. It becomes 0 after a write that stores any other value there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low |
| wr_en | input | 1 | Write strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the addressed register |
| lockstep_mode | output | 1 | Effective mode: 1 lockstep, 0 dual-core |
| cluster_rst | output | 1 | Cluster reset, active high |
| rom_wait_en | output | 1 | Insert one wait cycle on ROM access |
| mode_locked | output | 1 | Sticky flag: the one allowed mode change has happened |

## Verification
The bench builds the block with RST_CYCLES set to 5 and REG_ADDR set to 0x10, which leaves every other address free for the ignored-address checks. The short hold brings both the exact reset-length check and a retrigger in the middle of a sequence within a few cycles. Several power-on resets inside one run give fresh attempts at the single allowed change. The deferred path, the immediate path and the redundant-encoding cases can therefore each be checked from a clean start.

// File: rtl/lockstep_ctrl.sv
module lockstep_ctrl #(
  parameter int                 ADDR_W     = 8,
  parameter logic [ADDR_W-1:0]  REG_ADDR   = '0,
  parameter int                 RST_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              lockstep_mode,
  output logic              cluster_rst,
  output logic              rom_wait_en,
  output logic              mode_locked
);
  localparam int CW = $clog2(RST_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(RST_CYCLES - 1);

  logic [2:0]    mode_req, swait_req, wait_req;
  logic          busy;
  logic [CW-1:0] cnt;

  wire sel       = (addr == REG_ADDR);
  wire wr_hit    = wr_en && sel;
  wire trig      = wr_hit && (wdata[18:16] == 3'b111) && !busy;
  wire want_lock = |mode_req;
  wire deferred  = &swait_req;
  wire latch_now = busy && (cnt == '0);
  wire apply     = !mode_locked && (want_lock != lockstep_mode) &&
                   (deferred ? latch_now : 1'b1);

  assign rdata = sel ? {5'b0, wait_req, 8'b0, 5'b0, swait_req, 5'b0, mode_req} : 32'h0;
  assign cluster_rst = busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_req    <= 3'b111;
      swait_req   <= 3'b111;
      wait_req    <= 3'b000;
      rom_wait_en <= 1'b0;
    end else if (wr_hit) begin
      mode_req    <= wdata[2:0];
      swait_req   <= wdata[10:8];
      wait_req    <= wdata[26:24];
      rom_wait_en <= (wdata[26:24] == 3'b111);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (trig) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy) begin
      if (cnt == LAST) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lockstep_mode <= 1'b1;
      mode_locked   <= 1'b0;
    end else if (apply) begin
      lockstep_mode <= want_lock;
      mode_locked   <= 1'b1;
    end
  end
endmodule

// File: rtl/lockstep_ctrl_chk.sv
module lockstep_ctrl_chk #(
  parameter int                 ADDR_W     = 8,
  parameter logic [ADDR_W-1:0]  REG_ADDR   = '0,
  parameter int                 RST_CYCLES = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic [31:0]       rdata,
  input logic              lockstep_mode,
  input logic              cluster_rst,
  input logic              rom_wait_en,
  input logic              mode_locked
);
  int hold;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold <= 0;
    else if (cluster_rst) hold <= (hold < 1000000) ? hold + 1 : hold;
    else hold <= 0;
  end

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == REG_ADDR) |-> ((rdata & 32'hF8FFF8F8) == 32'h0));

  assert_hold_length_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cluster_rst) |-> (hold == RST_CYCLES));

  assert_start_by_trigger_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cluster_rst) |-> $past(wr_en && (addr == REG_ADDR) && (wdata[18:16] == 3'b111)));

  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mode_locked |=> mode_locked);

  assert_mode_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mode_locked |=> $stable(lockstep_mode));

  assert_change_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (lockstep_mode != $past(lockstep_mode)) |-> mode_locked);

  assert_wait_follows_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr == REG_ADDR)) |=> (rom_wait_en == ($past(wdata[26:24]) == 3'b111)));
endmodule

bind lockstep_ctrl lockstep_ctrl_chk #(
  .ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR), .RST_CYCLES(RST_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .rdata(rdata), .lockstep_mode(lockstep_mode), .cluster_rst(cluster_rst),
  .rom_wait_en(rom_wait_en), .mode_locked(mode_locked)
);

// File: tb/lockstep_ctrl_test.sv
module lockstep_ctrl_test;
  localparam int ADDR_W = 8;
  localparam logic [ADDR_W-1:0] RADDR = 8'h10;
  localparam int RC = 5;

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [ADDR_W-1:0] addr = RADDR;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic lockstep_mode, cluster_rst, rom_wait_en, mode_locked;

  always #5 clk = ~clk;

  lockstep_ctrl #(.ADDR_W(ADDR_W), .REG_ADDR(RADDR), .RST_CYCLES(RC)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .lockstep_mode(lockstep_mode), .cluster_rst(cluster_rst),
    .rom_wait_en(rom_wait_en), .mode_locked(mode_locked));

  typedef struct {
    string       req;
    string       what;
    int          src;
    logic [31:0] act;
    logic [31:0] exp;
  } item_t;

  item_t q[$];
  int compared = 0, mismatched = 0;
  bit done = 0;

  always @(negedge clk) begin
    #1;
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] a;
      it = q.pop_front();
      case (it.src)
        1: a = {31'b0, lockstep_mode};
        2: a = {31'b0, cluster_rst};
        3: a = {31'b0, rom_wait_en};
        4: a = {31'b0, mode_locked};
        5: a = rdata;
        default: a = it.act;
      endcase
      compared++;
      if (a !== it.exp) begin
        mismatched++;
        $display("FAIL %s %s: actual %h expected %h", it.req, it.what, a, it.exp);
      end
    end
  end

  task automatic expect_item(input int src, input logic [31:0] exp,
                             input string req, input string what,
                             input logic [31:0] act = 0);
    item_t it;
    it.req = req; it.what = what; it.src = src; it.exp = exp; it.act = act;
    q.push_back(it);
    wait (q.size() == 0);
  endtask

  task automatic power_on();
    @(negedge clk);
    rst_n = 0; wr_en = 0; addr = RADDR;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0; addr = RADDR;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    power_on();
    expect_item(5, 32'h00000707, "R1", "reset readback");
    expect_item(1, 1, "R1", "reset lockstep");
    expect_item(3, 0, "R1", "reset rom wait");
    expect_item(2, 0, "R1", "reset cluster_rst");
    expect_item(4, 0, "R1", "reset mode_locked");

    wr(RADDR, 32'hF8F80F0F);
    idle(2);
    expect_item(5, 32'h00000707, "R2", "reserved bits ignored");
    expect_item(2, 0, "R2", "reserved write no reset");
    wr(8'h22, 32'h00000000);
    idle(2);
    expect_item(5, 32'h00000707, "R2", "other address write ignored");
    expect_item(1, 1, "R2", "other address mode unchanged");
    addr = 8'h22;
    expect_item(5, 32'h0, "R2", "other address reads zero");
    addr = RADDR;

    wr(RADDR, 32'h07000707);
    expect_item(3, 1, "R10", "wait enabled");
    expect_item(5, 32'h07000707, "R10", "wait readback");
    wr(RADDR, 32'h03000707);
    expect_item(3, 0, "R10", "partial code disables");

    wr(RADDR, 32'h00000700);
    idle(3);
    expect_item(1, 1, "R4", "deferred not applied yet");
    expect_item(4, 0, "R4", "flag still clear");
    wr(RADDR, 32'h00010700);
    idle(1);
    expect_item(2, 0, "R6", "partial trigger ignored");
    expect_item(5, 32'h00000700, "R6", "trigger reads zero");
    wr(RADDR, 32'h00070700);
    begin
      int n = 0;
      while (cluster_rst === 1'b1 && n < 100) begin
        n++;
        if (n == 2) begin wr_en = 1; wdata = 32'h00070700; end
        else wr_en = 0;
        @(negedge clk);
      end
      wr_en = 0;
      expect_item(0, RC, "R8", "retrigger does not extend", n);
      expect_item(0, RC, "R7", "hold length", n);
    end
    expect_item(1, 0, "R7", "deferred mode latched");
    expect_item(4, 1, "R9", "flag set by change");
    expect_item(5, 32'h00000700, "R6", "trigger reads zero after run");

    wr(RADDR, 32'h00070707);
    idle(RC + 3);
    expect_item(1, 0, "R9", "second deferred change blocked");
    wr(RADDR, 32'h00000007);
    idle(3);
    expect_item(1, 0, "R9", "second immediate change blocked");
    expect_item(4, 1, "R9", "flag sticky");

    power_on();
    wr(RADDR, 32'h00000000);
    expect_item(1, 1, "R5", "not applied after one edge");
    idle(1);
    expect_item(1, 0, "R5", "immediate dual-core");
    expect_item(2, 0, "R5", "no cluster reset");
    expect_item(4, 1, "R9", "immediate sets flag");
    wr(RADDR, 32'h00000007);
    idle(2);
    expect_item(1, 0, "R9", "locked after immediate");

    power_on();
    wr(RADDR, 32'h00000001);
    idle(2);
    expect_item(1, 1, "R3", "code 001 stays lockstep");
    wr(RADDR, 32'h00000004);
    idle(2);
    expect_item(1, 1, "R3", "code 100 stays lockstep");
    expect_item(4, 0, "R3", "no change, flag clear");
    wr(RADDR, 32'h00000000);
    idle(1);
    expect_item(1, 0, "R3", "code 000 selects dual-core");

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule